// File: doc/BRIEF.md
# CRTC Raster Timing Generator

This block turns a set of legacy CRT-controller register values into a running raster. It counts pixels inside a character cell, characters along a line and lines down a frame. From those counts it produces an active-display enable, horizontal and vertical blanking, and horizontal and vertical sync pins whose polarity is chosen by the misc-output byte. Register bytes arrive already decoded, one port per register. The block itself rebuilds each 9-bit horizontal and 11-bit vertical field from the base byte and the overflow and extension bits that carry its upper bits.

Horizontal timing is counted in character clocks. A character is 8 pixels, or 16 pixels when double mode is selected; double mode is meant for pixel clocks above 135 MHz. Vertical timing is counted in scan lines. Each blanking and sync interval starts on a full-width equality with its start field. It ends when only the low bits of the counter match its narrow end field, so an end value can match after the counter wraps into the next line or frame.

Top module: `crtc_raster_gen`

## Requirements
- R1: While rst_n is low, pix_phase, h_count and v_count are zero and the internal blank and sync flags are cleared. With timing enabled this gives h_blank and v_blank low, and each sync pin at its inactive level.
- R2: pix_phase counts 0..7, or 0..15 when dbl_char is 1, then wraps to 0. h_count advances only in the cycle that follows a wrap of pix_phase.
- R3: h_count runs from 0 to HT+4, so a line is HT+5 characters, and then returns to 0. HT = {h_ext_r[0], h_total_r}.
- R4: v_count advances by one when h_count wraps. It runs from 0 to VT+1, so a frame is VT+2 lines, and then returns to 0. VT = {v_ext_r[0], v_ovf_r[5], v_ovf_r[0], v_total_r}. v_count is unchanged at every other time.
- R5: display_en is high exactly when timing is enabled, h_count <= {h_ext_r[2], h_disp_end_r} and v_count <= {v_ext_r[2], v_ovf_r[6], v_ovf_r[1], v_disp_end_r}.
- R6: The horizontal blank flag is updated each time h_count takes a new value n. It sets when n equals {h_ext_r[4], h_blank_start_r}. Otherwise it clears when n mod 128 equals {h_ext_r[5], h_sync_end_r[7], h_blank_end_r[4:0]}. The set condition takes priority. h_blank is this flag OR'd with the disabled state.
- R7: The horizontal sync flag sets when a new h_count equals {h_ext_r[6], h_sync_start_r}. Otherwise it clears when the new count mod 32 equals h_sync_end_r[4:0]. The set condition takes priority.
- R8: The vertical blank flag is updated each time v_count takes a new value n. It sets when n equals {v_ext_r[4], v_maxscan_r[5], v_ovf_r[3], v_blank_start_r}. Otherwise it clears when n mod 256 equals v_blank_end_r. v_blank is this flag OR'd with the disabled state.
- R9: The vertical sync flag sets when a new v_count equals {v_ext_r[6], v_ovf_r[7], v_ovf_r[2], v_sync_start_r}. Otherwise it clears when the new count mod 16 equals v_sync_end_r[3:0].
- R10: hsync equals the horizontal sync flag when misc_out[6] is 1, and its inverse when misc_out[6] is 0. vsync follows the vertical sync flag in the same way under misc_out[7].
- R11: While mode_ctl_r[7] is 0, each clock edge clears all counters and flags. In the same state display_en is low and both blanks are high.
- R12: blank is the OR of h_blank and v_blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbl_char | input | 1 | Selects 16-pixel characters |
| misc_out | input | 8 | Misc-output byte; bit 6 and bit 7 select sync polarity |
| h_total_r | input | 8 | Horizontal total, low byte |
| h_disp_end_r | input | 8 | Horizontal display end, low byte |
| h_blank_start_r | input | 8 | Horizontal blank start, low byte |
| h_blank_end_r | input | 8 | Horizontal blank end, bits 4:0 |
| h_sync_start_r | input | 8 | Horizontal sync start, low byte |
| h_sync_end_r | input | 8 | Horizontal sync end in 4:0, blank end bit 5 in bit 7 |
| v_total_r | input | 8 | Vertical total, low byte |
| v_ovf_r | input | 8 | Vertical overflow bits 8 and 9 |
| v_maxscan_r | input | 8 | Bit 5 holds vertical blank start bit 9 |
| v_sync_start_r | input | 8 | Vertical sync start, low byte |
| v_sync_end_r | input | 8 | Vertical sync end in 3:0 |
| v_disp_end_r | input | 8 | Vertical display end, low byte |
| v_blank_start_r | input | 8 | Vertical blank start, low byte |
| v_blank_end_r | input | 8 | Vertical blank end |
| mode_ctl_r | input | 8 | Bit 7 enables timing |
| h_ext_r | input | 8 | Horizontal extension bits |
| v_ext_r | input | 8 | Vertical extension bits (bit 10 of each field) |
| pix_phase | output | 4 | Pixel position within the character |
| h_count | output | 10 | Character counter |
| v_count | output | 12 | Line counter |
| display_en | output | 1 | Active display |
| h_blank | output | 1 | Horizontal blanking |
| v_blank | output | 1 | Vertical blanking |
| blank | output | 1 | Combined blanking |
| hsync | output | 1 | Horizontal sync pin after polarity |
| vsync | output | 1 | Vertical sync pin after polarity |

## Verification
Every counter and flag is a register that is updated at a rising edge. The outputs are plain combinations of those registers with the current register-byte inputs. A result therefore shows up in the same cycle as the edge that produces it, with no pipeline delay. The bench steps a reference state at each rising edge, using rules written from the requirements. It compares every output at the following falling edge, when both sides have settled and the inputs are stable. Configuration bytes are changed only while timing is disabled. This keeps a counter from ever sitting above a newly shortened total.

// File: rtl/crtc_raster_gen.sv
module crtc_raster_gen #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbl_char,
  input  logic [RW-1:0] misc_out,
  input  logic [RW-1:0] h_total_r,
  input  logic [RW-1:0] h_disp_end_r,
  input  logic [RW-1:0] h_blank_start_r,
  input  logic [RW-1:0] h_blank_end_r,
  input  logic [RW-1:0] h_sync_start_r,
  input  logic [RW-1:0] h_sync_end_r,
  input  logic [RW-1:0] v_total_r,
  input  logic [RW-1:0] v_ovf_r,
  input  logic [RW-1:0] v_maxscan_r,
  input  logic [RW-1:0] v_sync_start_r,
  input  logic [RW-1:0] v_sync_end_r,
  input  logic [RW-1:0] v_disp_end_r,
  input  logic [RW-1:0] v_blank_start_r,
  input  logic [RW-1:0] v_blank_end_r,
  input  logic [RW-1:0] mode_ctl_r,
  input  logic [RW-1:0] h_ext_r,
  input  logic [RW-1:0] v_ext_r,
  output logic [3:0]    pix_phase,
  output logic [RW+1:0] h_count,
  output logic [RW+3:0] v_count,
  output logic          display_en,
  output logic          h_blank,
  output logic          v_blank,
  output logic          blank,
  output logic          hsync,
  output logic          vsync
);
  localparam int HF  = RW + 1;
  localparam int VF  = RW + 3;
  localparam int HCW = HF + 1;
  localparam int VCW = VF + 1;
  localparam int HBE = 7;
  localparam int HSE = 5;
  localparam int VBE = 8;
  localparam int VSE = 4;

  logic [3:0]     pix_q;
  logic [HCW-1:0] hc_q;
  logic [VCW-1:0] vc_q;
  logic           hb_q, hs_q, vb_q, vs_q;

  wire ten = mode_ctl_r[7];

  wire [HF-1:0] h_tot  = {h_ext_r[0], h_total_r};
  wire [HF-1:0] h_disp = {h_ext_r[2], h_disp_end_r};
  wire [HF-1:0] h_bst  = {h_ext_r[4], h_blank_start_r};
  wire [HF-1:0] h_sst  = {h_ext_r[6], h_sync_start_r};
  wire [HBE-1:0] h_ben = {h_ext_r[5], h_sync_end_r[7], h_blank_end_r[4:0]};
  wire [HSE-1:0] h_sen = h_sync_end_r[4:0];

  wire [VF-1:0] v_tot  = {v_ext_r[0], v_ovf_r[5], v_ovf_r[0], v_total_r};
  wire [VF-1:0] v_disp = {v_ext_r[2], v_ovf_r[6], v_ovf_r[1], v_disp_end_r};
  wire [VF-1:0] v_bst  = {v_ext_r[4], v_maxscan_r[5], v_ovf_r[3], v_blank_start_r};
  wire [VF-1:0] v_sst  = {v_ext_r[6], v_ovf_r[7], v_ovf_r[2], v_sync_start_r};
  wire [VBE-1:0] v_ben = v_blank_end_r;
  wire [VSE-1:0] v_sen = v_sync_end_r[3:0];

  wire [3:0]     pix_last = dbl_char ? 4'd15 : 4'd7;
  wire [HCW-1:0] h_last   = {1'b0, h_tot} + HCW'(4);
  wire [VCW-1:0] v_last   = {1'b0, v_tot} + VCW'(1);

  wire ch_end = pix_q >= pix_last;
  wire ln_end = ch_end && (hc_q >= h_last);
  wire fr_end = ln_end && (vc_q >= v_last);

  wire [HCW-1:0] hc_n = ln_end ? '0 : hc_q + HCW'(1);
  wire [VCW-1:0] vc_n = fr_end ? '0 : vc_q + VCW'(1);

  wire hb_set = hc_n == {1'b0, h_bst};
  wire hs_set = hc_n == {1'b0, h_sst};
  wire vb_set = vc_n == {1'b0, v_bst};
  wire vs_set = vc_n == {1'b0, v_sst};
  wire hb_clr = hc_n[HBE-1:0] == h_ben;
  wire hs_clr = hc_n[HSE-1:0] == h_sen;
  wire vb_clr = vc_n[VBE-1:0] == v_ben;
  wire vs_clr = vc_n[VSE-1:0] == v_sen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      hc_q  <= '0;
      vc_q  <= '0;
      hb_q  <= 1'b0;
      hs_q  <= 1'b0;
      vb_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else if (!ten) begin
      pix_q <= '0;
      hc_q  <= '0;
      vc_q  <= '0;
      hb_q  <= 1'b0;
      hs_q  <= 1'b0;
      vb_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      pix_q <= ch_end ? 4'd0 : pix_q + 4'd1;
      if (ch_end) begin
        hc_q <= hc_n;
        hb_q <= hb_set | (hb_q & ~hb_clr);
        hs_q <= hs_set | (hs_q & ~hs_clr);
      end
      if (ln_end) begin
        vc_q <= vc_n;
        vb_q <= vb_set | (vb_q & ~vb_clr);
        vs_q <= vs_set | (vs_q & ~vs_clr);
      end
    end
  end

  assign pix_phase  = pix_q;
  assign h_count    = hc_q;
  assign v_count    = vc_q;
  assign display_en = ten && (hc_q <= {1'b0, h_disp}) && (vc_q <= {1'b0, v_disp});
  assign h_blank    = ~ten | hb_q;
  assign v_blank    = ~ten | vb_q;
  assign blank      = h_blank | v_blank;
  assign hsync      = misc_out[6] ? hs_q : ~hs_q;
  assign vsync      = misc_out[7] ? vs_q : ~vs_q;
endmodule

// File: rtl/crtc_raster_gen_chk.sv
module crtc_raster_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dbl_char,
  input logic [7:0] misc_out,
  input logic [7:0] h_total_r,
  input logic [7:0] h_ext_r,
  input logic [7:0] mode_ctl_r,
  input logic [3:0] pix_phase,
  input logic [9:0] h_count,
  input logic [11:0] v_count,
  input logic       display_en,
  input logic       blank,
  input logic       hsync,
  input logic       vsync
);
  wire       en    = mode_ctl_r[7];
  wire [3:0] plim  = dbl_char ? 4'd15 : 4'd7;
  wire [9:0] hlim  = {1'b0, h_ext_r[0], h_total_r} + 10'd4;
  wire       wrapn = (pix_phase >= plim) && (h_count >= hlim);

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pix_phase == 4'd0 && h_count == 10'd0 && v_count == 12'd0)); // R11
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!display_en && blank)); // R11
  AST_CHAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pix_phase < plim) |=> (h_count == $past(h_count) && pix_phase == $past(pix_phase) + 4'd1)); // R2
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrapn) |=> (h_count == 10'd0)); // R3
  AST_V_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrapn) |=> $stable(v_count)); // R4
  AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hsync != misc_out[6] && vsync != misc_out[7])); // R10
endmodule

bind crtc_raster_gen crtc_raster_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbl_char(dbl_char), .misc_out(misc_out),
  .h_total_r(h_total_r), .h_ext_r(h_ext_r), .mode_ctl_r(mode_ctl_r),
  .pix_phase(pix_phase), .h_count(h_count), .v_count(v_count),
  .display_en(display_en), .blank(blank), .hsync(hsync), .vsync(vsync)
);

// File: tb/sim_crtc_raster_gen.sv
module sim_crtc_raster_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, dbl = 1'b0;
  logic [7:0] misc = 8'hC0;
  logic [7:0] hto, hde, hbs, hbe, hss, hse, vto, ovf, msl, vss, vse, vde, vbs, vbe, mctl, hex, vex;
  logic [3:0] pix_phase;
  logic [9:0] h_count;
  logic [11:0] v_count;
  logic display_en, h_blank, v_blank, blank, hsync, vsync;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_pix, m_h, m_v, nh, nv;
  logic m_hb, m_hs, m_vb, m_vs;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_raster_gen u0 (
    .clk(clk), .rst_n(rst_n), .dbl_char(dbl), .misc_out(misc),
    .h_total_r(hto), .h_disp_end_r(hde), .h_blank_start_r(hbs), .h_blank_end_r(hbe),
    .h_sync_start_r(hss), .h_sync_end_r(hse), .v_total_r(vto), .v_ovf_r(ovf),
    .v_maxscan_r(msl), .v_sync_start_r(vss), .v_sync_end_r(vse), .v_disp_end_r(vde),
    .v_blank_start_r(vbs), .v_blank_end_r(vbe), .mode_ctl_r(mctl), .h_ext_r(hex),
    .v_ext_r(vex), .pix_phase(pix_phase), .h_count(h_count), .v_count(v_count),
    .display_en(display_en), .h_blank(h_blank), .v_blank(v_blank), .blank(blank),
    .hsync(hsync), .vsync(vsync));

  function automatic int f_ht();  return hex[0]*256 + hto; endfunction
  function automatic int f_hd();  return hex[2]*256 + hde; endfunction
  function automatic int f_hbs(); return hex[4]*256 + hbs; endfunction
  function automatic int f_hss(); return hex[6]*256 + hss; endfunction
  function automatic int f_hbe(); return hex[5]*64 + hse[7]*32 + hbe[4:0]; endfunction
  function automatic int f_vt();  return vex[0]*1024 + ovf[5]*512 + ovf[0]*256 + vto; endfunction
  function automatic int f_vd();  return vex[2]*1024 + ovf[6]*512 + ovf[1]*256 + vde; endfunction
  function automatic int f_vbs(); return vex[4]*1024 + msl[5]*512 + ovf[3]*256 + vbs; endfunction
  function automatic int f_vss(); return vex[6]*1024 + ovf[7]*512 + ovf[2]*256 + vss; endfunction

  // reference state, stepped from the requirement rules
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !mctl[7]) begin
      m_pix <= 0; m_h <= 0; m_v <= 0;
      m_hb <= 0; m_hs <= 0; m_vb <= 0; m_vs <= 0;
    end else if (m_pix >= (dbl ? 15 : 7)) begin
      m_pix <= 0;
      nh = (m_h >= f_ht() + 4) ? 0 : m_h + 1;
      m_h <= nh;
      m_hb <= (nh == f_hbs()) ? 1'b1 : ((nh % 128) == f_hbe()) ? 1'b0 : m_hb;
      m_hs <= (nh == f_hss()) ? 1'b1 : ((nh % 32) == int'(hse[4:0])) ? 1'b0 : m_hs;
      if (m_h >= f_ht() + 4) begin
        nv = (m_v >= f_vt() + 1) ? 0 : m_v + 1;
        m_v <= nv;
        m_vb <= (nv == f_vbs()) ? 1'b1 : ((nv % 256) == int'(vbe)) ? 1'b0 : m_vb;
        m_vs <= (nv == f_vss()) ? 1'b1 : ((nv % 16) == int'(vse[3:0])) ? 1'b0 : m_vs;
      end
    end else begin
      m_pix <= m_pix + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    logic ehb, evb, ede;
    ede = mctl[7] && m_h <= f_hd() && m_v <= f_vd();
    ehb = !mctl[7] || m_hb;
    evb = !mctl[7] || m_vb;
    chk("R2 pix_phase", int'(pix_phase), m_pix);
    chk("R3 h_count", int'(h_count), m_h);
    chk("R4 v_count", int'(v_count), m_v);
    chk("R5 display_en", int'(display_en), int'(ede));
    chk("R6 h_blank", int'(h_blank), int'(ehb));
    chk("R7 R10 hsync", int'(hsync), int'(misc[6] ? m_hs : !m_hs));
    chk("R8 v_blank", int'(v_blank), int'(evb));
    chk("R9 R10 vsync", int'(vsync), int'(misc[7] ? m_vs : !m_vs));
    chk("R12 blank", int'(blank), int'(ehb || evb));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic hold_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R11 counters held", int'(pix_phase) + int'(h_count) + int'(v_count), 0);
      chk("R11 display_en low", int'(display_en), 0);
      chk("R11 blank high", int'(h_blank && v_blank), 1);
      chk("R11 R10 sync idle", int'(hsync == misc[6] || vsync == misc[7]), 0);
    end
  endtask

  task automatic base_cfg();
    hto = 8'd3; hde = 8'd4; hbs = 8'd5; hbe = 8'd7; hss = 8'd6; hse = 8'd7;
    vto = 8'd4; vde = 8'd2; vbs = 8'd3; vbe = 8'd5; vss = 8'd4; vse = 8'd5;
    ovf = 8'h00; msl = 8'h00; hex = 8'h00; vex = 8'h00;
  endtask

  task automatic disable_now();
    @(negedge clk);
    mctl = 8'h00;
    hold_check(2);
  endtask

  initial begin
    base_cfg();
    mctl = 8'h80;
    #1;
    // R1: state while reset is asserted, timing enabled
    chk("R1 counters", int'(pix_phase) + int'(h_count) + int'(v_count), 0);
    chk("R1 h_blank", int'(h_blank), 0);
    chk("R1 v_blank", int'(v_blank), 0);
    chk("R1 hsync inactive", int'(hsync), 0);
    chk("R1 vsync inactive", int'(vsync), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // small frame, positive syncs, 8-pixel characters
    run(3 * 384 + 20);

    // double mode, negative syncs
    disable_now();
    dbl = 1'b1; misc = 8'h00; mctl = 8'h80;
    run(2 * 768 + 20);

    // mixed polarity, R11 mid-line hold and restart
    disable_now();
    dbl = 1'b0; misc = 8'h40; mctl = 8'h80;
    run(200);
    disable_now();
    hold_check(3);
    mctl = 8'h80;
    run(400);

    // horizontal extension bits and low-bit end matching after wrap
    disable_now();
    misc = 8'hC0;
    hex = 8'h75; hto = 8'h02; hde = 8'h00; hbs = 8'h01; hbe = 8'h05; hse = 8'h83;
    hss = 8'h02; vto = 8'd2;
    mctl = 8'h80;
    run(2 * 263 * 8 * 4 + 50);

    // vertical overflow bits 8
    disable_now();
    base_cfg();
    hto = 8'd0; ovf = 8'h0F; vto = 8'd4; vde = 8'd1; vbs = 8'd2; vbe = 8'd3;
    vss = 8'd0; vse = 8'd1;
    mctl = 8'h80;
    run(13000);

    // vertical bits 9 and 10 placed beyond the frame
    disable_now();
    base_cfg();
    ovf = 8'hC0; msl = 8'h20; vex = 8'h54; vde = 8'd0; vbs = 8'd1; vss = 8'd2; vse = 8'd9;
    mctl = 8'h80;
    run(3 * 384);

    // double mode with extension total
    disable_now();
    base_cfg();
    dbl = 1'b1; hex = 8'h01; hto = 8'd0; vto = 8'd1; misc = 8'h80;
    mctl = 8'h80;
    run(261 * 16 * 3 + 30);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 190000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule